// File: doc/BRIEF.md
# Dual-Rate Gated Timer/Counter Channel

This block is one timer/counter channel of the kind found in small 8-bit controllers. It holds a count split into a high byte and a low byte. It advances that count either from an internal time base or from falling edges on an external count pin. A run bit and an optional external gate pin together decide whether counting is allowed. When the count wraps to zero, a sticky overflow flag is set, and that flag can serve as an interrupt request.

The internal time base is a free-running prescaler. It divides the system clock by 12 by default, or by 4 when the fast-rate bit is set. Changing the rate restarts the prescaler, so the first tick at the new rate arrives one full period after the change.

Two counting widths are supported:
- In the 13-bit mode, the lower five bits of the low byte act as a prescaler stage in front of the high byte.
- In the 16-bit mode, both bytes form one 16-bit counter.

Software writes the control fields, both count bytes and the overflow flag through dedicated write strobes.

Top module: `dual_rate_timer`

## Requirements
- R1: After reset, both count bytes and the overflow flag read 0. The control state after reset is: timer source, no gating, 13-bit mode, stopped, divide-by-12 rate.
- R2: With the timer source selected (`cfg_ext_sel`=0), the count advances exactly once every 12 clock cycles when `rate_fast`=0, and exactly once every 4 clock cycles when `rate_fast`=1.
- R3: Counting takes place only when the run bit is 1 and either `cfg_gate_en`=0 or the synchronized `gate_pin` is 1.
- R4: With `cfg_ext_sel`=1, each 1-to-0 transition of `cnt_pin` advances the count once. The pin passes through two synchronizer flops plus an edge flop, so the count changes at the third rising clock edge after the pin is first sampled low.
- R5: With `cfg_mode`=2'b00 (13-bit mode), only bits [4:0] of the low byte count. The high byte increments when those bits wrap from 5'h1F to 0. Low-byte bits [7:5] keep their last written value.
- R6: In the 13-bit mode, an increment from high byte 8'hFF and low bits 5'h1F wraps the count to zero and sets the overflow flag.
- R7: With `cfg_mode`=2'b01 (16-bit mode), both bytes form one counter, and the step from 16'hFFFF to 16'h0000 sets the overflow flag.
- R8: With `cfg_mode`=2'b10 or 2'b11, the count holds its value whatever the count source does.
- R9: The overflow flag stays set until a write with `ovf_we`=1 loads `ovf_wdata`. If an overflow and a write of 0 fall in the same cycle, the flag ends up 1.
- R10: `hi_we` or `lo_we` loads `cnt_wdata` into that byte at the next clock edge. Any count-byte write suppresses the increment of that cycle, including its carry and its overflow.
- R11: A write that changes the rate bit restarts the prescaler. The first tick at the new rate advances the count 4 cycles after the write edge in the fast rate, or 12 cycles after it in the slow rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin | input | 1 | External count input; falling edges are counted |
| gate_pin | input | 1 | External gate input; high permits counting when gating is on |
| cfg_we | input | 1 | Write strobe for source, gate and mode fields |
| cfg_ext_sel | input | 1 | 1 selects the external count pin, 0 the internal time base |
| cfg_gate_en | input | 1 | 1 makes counting depend on `gate_pin` |
| cfg_mode | input | 2 | 00 13-bit, 01 16-bit, 1x hold |
| run_we | input | 1 | Write strobe for the run bit |
| run_d | input | 1 | New run bit value |
| rate_we | input | 1 | Write strobe for the rate bit |
| rate_fast | input | 1 | 1 selects divide-by-4, 0 selects divide-by-12 |
| hi_we | input | 1 | Load strobe for the high count byte |
| lo_we | input | 1 | Load strobe for the low count byte |
| cnt_wdata | input | DATA_W | Data for count-byte loads |
| ovf_we | input | 1 | Write strobe for the overflow flag |
| ovf_wdata | input | 1 | Value loaded into the overflow flag |
| cnt_hi | output | DATA_W | High count byte |
| cnt_lo | output | DATA_W | Low count byte |
| ovf_flag | output | 1 | Sticky overflow flag, usable as an interrupt request |

## Verification
Two kinds of event can land on the same clock edge:
- a hardware overflow and a software write that clears the flag;
- a count increment and a software load of a count byte.

The bench provokes both with the external count source, because its three-edge latency is exact. It loads 16'hFFFF or a known value, drops the count pin, and places the flag write or the byte load on exactly the third edge. It then checks that the flag reads 1 after the collision, and that a colliding byte load leaves the written value with no carry into the other byte. Constrained random traffic adds further coincidences of writes, gate changes and rate switches, and a cycle-accurate model in the bench judges every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_W13  = 2'b00,
    MODE_W16  = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_RSV  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      ext_sel;
    logic      gate_en;
    tmr_mode_e mode;
  } tmr_cfg_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  input  logic restart,
  output logic tick
);

  localparam int W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [W-1:0] SLOW_LAST = W'(SLOW_DIV - 1);
  localparam logic [W-1:0] FAST_LAST = W'(FAST_DIV - 1);

  logic [W-1:0] div_q;
  logic [W-1:0] last;

  assign last = fast ? FAST_LAST : SLOW_LAST;
  assign tick = (div_q == last);

  always_ff @(posedge clk) begin
    if (rst)          div_q <= '0;
    else if (restart) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode,
  input  logic              inc,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo,
  output logic              ovf_pulse
);

  logic [PRE_BITS-1:0] lo_low;
  logic [DATA_W-1:0]   lo_next;
  logic                carry;
  logic                step_ok;
  logic                bump;

  assign lo_low = lo[PRE_BITS-1:0];

  always_comb begin
    step_ok = 1'b0;
    carry   = 1'b0;
    lo_next = lo;
    case (mode)
      MODE_W13: begin
        step_ok = 1'b1;
        carry   = &lo_low;
        lo_next = {lo[DATA_W-1:PRE_BITS], lo_low + 1'b1};
      end
      MODE_W16: begin
        step_ok = 1'b1;
        carry   = &lo;
        lo_next = lo + 1'b1;
      end
      default: begin
        step_ok = 1'b0;
      end
    endcase
  end

  assign bump      = inc & step_ok & ~hi_we & ~lo_we;
  assign ovf_pulse = bump & carry & (&hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else begin
      if (hi_we)              hi <= wdata;
      else if (bump && carry) hi <= hi + 1'b1;
      if (lo_we)              lo <= wdata;
      else if (bump)          lo <= lo_next;
    end
  end

endmodule

// File: rtl/dual_rate_timer.sv
module dual_rate_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_BITS    = 5,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              cfg_we,
  input  logic              cfg_ext_sel,
  input  logic              cfg_gate_en,
  input  logic [1:0]        cfg_mode,
  input  logic              run_we,
  input  logic              run_d,
  input  logic              rate_we,
  input  logic              rate_fast,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [DATA_W-1:0] cnt_wdata,
  input  logic              ovf_we,
  input  logic              ovf_wdata,
  output logic [DATA_W-1:0] cnt_hi,
  output logic [DATA_W-1:0] cnt_lo,
  output logic              ovf_flag
);

  tmr_cfg_t   cfg_q;
  logic       run_q;
  logic       fast_q;
  logic [1:0] mode_q;
  logic       rate_restart;
  logic       tick;
  logic       gate_lvl;
  logic       cnt_fall;
  logic       cnt_lvl_unused;
  logic       gate_fall_unused;
  logic       count_en;
  logic       cnt_inc;
  logic       ovf_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '{ext_sel: 1'b0, gate_en: 1'b0, mode: MODE_W13};
      run_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q.ext_sel <= cfg_ext_sel;
        cfg_q.gate_en <= cfg_gate_en;
        cfg_q.mode    <= tmr_mode_e'(cfg_mode);
      end
      if (run_we)  run_q  <= run_d;
      if (rate_we) fast_q <= rate_fast;
    end
  end

  assign mode_q       = cfg_q.mode;
  assign rate_restart = rate_we & (rate_fast != fast_q);

  tmr_prescale #(
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV)
  ) u_pre (
    .clk    (clk),
    .rst    (rst),
    .fast   (fast_q),
    .restart(rate_restart),
    .tick   (tick)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_cnt (
    .clk  (clk),
    .rst  (rst),
    .pin  (cnt_pin),
    .level(cnt_lvl_unused),
    .fall (cnt_fall)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
    .clk  (clk),
    .rst  (rst),
    .pin  (gate_pin),
    .level(gate_lvl),
    .fall (gate_fall_unused)
  );

  assign count_en = run_q & (~cfg_q.gate_en | gate_lvl);
  assign cnt_inc  = count_en & (cfg_q.ext_sel ? cnt_fall : tick);

  tmr_count #(
    .DATA_W  (DATA_W),
    .PRE_BITS(PRE_BITS)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_q.mode),
    .inc      (cnt_inc),
    .hi_we    (hi_we),
    .lo_we    (lo_we),
    .wdata    (cnt_wdata),
    .hi       (cnt_hi),
    .lo       (cnt_lo),
    .ovf_pulse(ovf_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)            ovf_flag <= 1'b0;
    else if (ovf_pulse) ovf_flag <= 1'b1;
    else if (ovf_we)    ovf_flag <= ovf_wdata;
  end

endmodule

// File: rtl/dual_rate_timer_chk.sv
module dual_rate_timer_chk #(
  parameter int DATA_W   = 8,
  parameter int PRE_BITS = 5,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hi_we,
  input logic              lo_we,
  input logic [DATA_W-1:0] cnt_wdata,
  input logic              ovf_we,
  input logic              ovf_wdata,
  input logic [DATA_W-1:0] cnt_hi,
  input logic [DATA_W-1:0] cnt_lo,
  input logic              ovf_flag,
  input logic [1:0]        mode_q,
  input logic              tick,
  input logic              fast_q,
  input logic              rate_restart
);

  localparam int GW = $clog2(SLOW_DIV + 1) + 1;

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || tick || rate_restart) gap <= '0;
    else                             gap <= gap + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt_hi == '0 && cnt_lo == '0 && !ovf_flag));

  // R2 and R11: tick spacing follows the selected rate since the last restart
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == GW'(fast_q ? FAST_DIV - 1 : SLOW_DIV - 1)));

  // R6 and R7: a flag rise not caused by software means the count wrapped
  assert_ovf_wraps_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf_flag) && !$past(ovf_we)) |->
      (cnt_hi == '0 && cnt_lo[PRE_BITS-1:0] == '0));

  assert_hold_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && !hi_we && !lo_we) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(ovf_we && !ovf_wdata)) |=> ovf_flag);

  assert_load_hi_R10: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (cnt_hi == $past(cnt_wdata)));

  assert_load_lo_R10: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (cnt_lo == $past(cnt_wdata)));

endmodule

bind dual_rate_timer dual_rate_timer_chk #(
  .DATA_W  (DATA_W),
  .PRE_BITS(PRE_BITS),
  .SLOW_DIV(SLOW_DIV),
  .FAST_DIV(FAST_DIV)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hi_we       (hi_we),
  .lo_we       (lo_we),
  .cnt_wdata   (cnt_wdata),
  .ovf_we      (ovf_we),
  .ovf_wdata   (ovf_wdata),
  .cnt_hi      (cnt_hi),
  .cnt_lo      (cnt_lo),
  .ovf_flag    (ovf_flag),
  .mode_q      (mode_q),
  .tick        (tick),
  .fast_q      (fast_q),
  .rate_restart(rate_restart)
);

// File: tb/dual_rate_timer_bench.sv
module dual_rate_timer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_pin = 1'b1, gate_pin = 1'b0;
  logic       cfg_we = 0, cfg_ext_sel = 0, cfg_gate_en = 0;
  logic [1:0] cfg_mode = 2'b00;
  logic       run_we = 0, run_d = 0, rate_we = 0, rate_fast = 0;
  logic       hi_we = 0, lo_we = 0, ovf_we = 0, ovf_wdata = 0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt_hi, cnt_lo;
  logic       ovf_flag;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // reference state
  logic [7:0] m_hi, m_lo;
  logic       m_flag, m_s1, m_s2, m_prev, m_g1, m_g2;
  logic       m_ext, m_gate, m_run, m_fast;
  logic [1:0] m_mode;
  int         m_pre;

  always #4 clk = ~clk;

  dual_rate_timer u_dual_rate_timer (
    .clk(clk), .rst(rst), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .cfg_we(cfg_we), .cfg_ext_sel(cfg_ext_sel), .cfg_gate_en(cfg_gate_en),
    .cfg_mode(cfg_mode), .run_we(run_we), .run_d(run_d),
    .rate_we(rate_we), .rate_fast(rate_fast), .hi_we(hi_we), .lo_we(lo_we),
    .cnt_wdata(cnt_wdata), .ovf_we(ovf_we), .ovf_wdata(ovf_wdata),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic tick, fall, en, inc, ovf;
    logic [7:0] nh, nl;
    if (rst) begin
      m_hi = 0; m_lo = 0; m_flag = 0; m_pre = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_g1 = 0; m_g2 = 0;
      m_ext = 0; m_gate = 0; m_run = 0; m_fast = 0; m_mode = 0;
      return;
    end
    tick = (m_pre == (m_fast ? 3 : 11));
    fall = m_prev && !m_s2;
    en   = m_run && (!m_gate || m_g2);
    inc  = en && (m_ext ? fall : tick);
    ovf  = 0;
    nh = m_hi; nl = m_lo;
    if (hi_we || lo_we) begin
      if (hi_we) nh = cnt_wdata;
      if (lo_we) nl = cnt_wdata;
    end else if (inc && m_mode == 2'b00) begin
      if (m_lo[4:0] == 5'h1F) begin
        nl = {m_lo[7:5], 5'h00};
        nh = m_hi + 8'd1;
        ovf = (m_hi == 8'hFF);
      end else nl = m_lo + 8'd1;
    end else if (inc && m_mode == 2'b01) begin
      nl = m_lo + 8'd1;
      if (m_lo == 8'hFF) begin
        nh = m_hi + 8'd1;
        ovf = (m_hi == 8'hFF);
      end
    end
    if (ovf)         m_flag = 1;
    else if (ovf_we) m_flag = ovf_wdata;
    if (rate_we && rate_fast != m_fast) m_pre = 0;
    else if (tick)                      m_pre = 0;
    else                                m_pre = m_pre + 1;
    m_hi = nh; m_lo = nl;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
    m_g2 = m_g1; m_g1 = gate_pin;
    if (cfg_we) begin m_ext = cfg_ext_sel; m_gate = cfg_gate_en; m_mode = cfg_mode; end
    if (run_we)  m_run  = run_d;
    if (rate_we) m_fast = rate_fast;
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(cur_tag, {cnt_hi, cnt_lo, 7'd0, ovf_flag}, {m_hi, m_lo, 7'd0, m_flag});
      cfg_we = 0; run_we = 0; rate_we = 0; hi_we = 0; lo_we = 0; ovf_we = 0;
    end
  endtask

  task automatic set_cfg(input logic ext, input logic gate, input logic [1:0] mode);
    cfg_we = 1; cfg_ext_sel = ext; cfg_gate_en = gate; cfg_mode = mode;
    cyc(1);
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    hi_we = 1; cnt_wdata = h; cyc(1);
    lo_we = 1; cnt_wdata = l; cyc(1);
  endtask

  task automatic fall_edge();
    cnt_pin = 0; cyc(3);
    cnt_pin = 1; cyc(3);
  endtask

  function automatic int cnt16();
    return {cnt_hi, cnt_lo};
  endfunction

  initial begin
    int v;
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(3);
    chk("R1", {cnt_hi, cnt_lo, 7'd0, ovf_flag}, 0);
    rst = 0;
    cyc(1);
    chk("R1", cnt16(), 0);

    // R2: timer source, both rates
    cur_tag = "R2";
    set_cfg(0, 0, 2'b01);
    run_we = 1; run_d = 1; cyc(1);
    v = cnt16(); cyc(120);
    chk("R2", cnt16() - v, 10);
    // R11: rate change restarts the prescaler
    cur_tag = "R11";
    rate_we = 1; rate_fast = 1; cyc(1);
    v = cnt16(); cyc(3);
    chk("R11", cnt16(), v);
    cyc(1);
    chk("R11", cnt16(), v + 1);
    cyc(36);
    chk("R2", cnt16() - v, 10);
    rate_we = 1; rate_fast = 0; cyc(1);
    v = cnt16(); cyc(11);
    chk("R11", cnt16(), v);
    cyc(1);
    chk("R11", cnt16(), v + 1);

    // R3: gating and run
    cur_tag = "R3";
    gate_pin = 0;
    set_cfg(0, 1, 2'b01);
    v = cnt16(); cyc(60);
    chk("R3", cnt16(), v);
    gate_pin = 1; cyc(62);
    chk("R3", int'(cnt16() != v), 1);
    run_we = 1; run_d = 0; cyc(1);
    v = cnt16(); cyc(60);
    chk("R3", cnt16(), v);

    // R4: external falling edges
    cur_tag = "R4";
    set_cfg(1, 0, 2'b01);
    run_we = 1; run_d = 1; cyc(1);
    load(8'h00, 8'h00);
    cnt_pin = 0; cyc(2);
    chk("R4", cnt16(), 0);
    cyc(1);
    chk("R4", cnt16(), 1);
    cnt_pin = 1; cyc(3);
    for (int k = 0; k < 5; k++) fall_edge();
    chk("R4", cnt16(), 6);

    // R5, R6: 13-bit mode carry and overflow
    cur_tag = "R5";
    set_cfg(1, 0, 2'b00);
    load(8'h12, 8'h5F);
    fall_edge();
    chk("R5", cnt16(), 16'h1340);
    cur_tag = "R6";
    load(8'hFF, 8'hBF);
    ovf_we = 1; ovf_wdata = 0; cyc(1);
    fall_edge();
    chk("R6", {cnt16(), 7'd0, ovf_flag}, {16'h00A0, 8'h01});

    // R9: stickiness and software clear
    cur_tag = "R9";
    cyc(20);
    chk("R9", ovf_flag, 1);
    ovf_we = 1; ovf_wdata = 0; cyc(1);
    chk("R9", ovf_flag, 0);

    // R7: 16-bit rollover
    cur_tag = "R7";
    set_cfg(1, 0, 2'b01);
    load(8'hFF, 8'hFE);
    fall_edge();
    chk("R7", {cnt16(), 7'd0, ovf_flag}, {16'hFFFF, 8'h00});
    fall_edge();
    chk("R7", {cnt16(), 7'd0, ovf_flag}, {16'h0000, 8'h01});

    // R9: overflow collides with a clear
    cur_tag = "R9";
    ovf_we = 1; ovf_wdata = 0; cyc(1);
    load(8'hFF, 8'hFF);
    cnt_pin = 0; cyc(2);
    ovf_we = 1; ovf_wdata = 0; cyc(1);
    chk("R9", {cnt16(), 7'd0, ovf_flag}, {16'h0000, 8'h01});
    cnt_pin = 1; cyc(3);

    // R10: byte load collides with an increment
    cur_tag = "R10";
    load(8'h03, 8'h10);
    cnt_pin = 0; cyc(2);
    lo_we = 1; cnt_wdata = 8'h77; cyc(1);
    chk("R10", cnt16(), 16'h0377);
    cnt_pin = 1; cyc(3);
    load(8'h00, 8'hFF);
    cnt_pin = 0; cyc(2);
    lo_we = 1; cnt_wdata = 8'hFF; cyc(1);
    chk("R10", cnt16(), 16'h00FF);
    cnt_pin = 1; cyc(3);

    // R8: hold codes
    cur_tag = "R8";
    set_cfg(1, 0, 2'b10);
    v = cnt16();
    for (int k = 0; k < 3; k++) fall_edge();
    chk("R8", cnt16(), v);
    set_cfg(1, 0, 2'b11);
    for (int k = 0; k < 3; k++) fall_edge();
    chk("R8", cnt16(), v);

    // random traffic judged by the model each cycle (R3 with R2, R4, R9, R10)
    cur_tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) cnt_pin = ~cnt_pin;
      if ($urandom_range(0, 15) == 0) gate_pin = ~gate_pin;
      if ($urandom_range(0, 99) == 0) begin
        cfg_we = 1; cfg_ext_sel = 1'($urandom); cfg_gate_en = 1'($urandom);
        cfg_mode = ($urandom_range(0, 7) == 0) ? 2'b10 : 2'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 149) == 0) begin run_we = 1; run_d = ($urandom_range(0, 3) != 0); end
      if ($urandom_range(0, 199) == 0) begin rate_we = 1; rate_fast = 1'($urandom); end
      if ($urandom_range(0, 59) == 0) begin
        cnt_wdata = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
        if ($urandom_range(0, 1) == 1) hi_we = 1; else lo_we = 1;
      end
      if ($urandom_range(0, 39) == 0) begin ovf_we = 1; ovf_wdata = 1'($urandom); end
      cyc(1);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule